// File: doc/BRIEF.md
# Two-Wire Register-Access Slave with Low-Clock Timeout

This block is a target on a two-wire serial bus (one clock line, one open-drain data line). It watches both lines from a fast system clock, recognises start, repeated-start and stop conditions, and answers to one 7-bit address. The top three address bits are the constant 110. The bottom four come from strap inputs, so up to sixteen copies can share one bus. Behind the address sits a small bank of byte-wide registers. The bank drives the block's outputs, and the master reaches it through a register pointer.

A write transfer carries the address with direction bit 0, then a command byte that loads the pointer, then one or more data bytes. A read transfer carries the address with direction bit 1 and returns the register under the pointer. It is reached either by a repeated start after a command byte, or directly with the pointer kept from earlier transfers. The block never drives the data line high. It only enables a pull-down, and the bus pull-up supplies the high level. If the clock line stays low for a parameterised number of system clocks, the block abandons the transfer and lets go of the data line.

Top module: `tw_reg_slave`

## Requirements
- R1: A falling data line while the clock is high is a start: from any state it begins a new address byte. A rising data line while the clock is high is a stop: it returns the block to idle. A data byte cut off by either one is not written.
- R2: The own address is {110, strap_i[3:0]}, carried in the upper seven bits of the first byte with the direction bit in bit 0. On a match, the block pulls data low for the 9th clock. Otherwise it releases the line and ignores every later byte until the next start.
- R3: Within a write, the command byte's low log2(NREG) bits load the pointer. Each data byte is written to the register under the pointer only when the falling clock edge that ends its acknowledge arrives. The command byte and the data bytes are all acknowledged.
- R4: After each written byte the pointer advances by one, wrapping from NREG-1 to 0. Consecutive data bytes therefore fill consecutive registers.
- R5: After a command byte, a repeated start plus the address with bit 0 = 1 makes the block shift out the selected register, most significant bit first, one bit per clock.
- R6: A read that opens directly with the address and bit 0 = 1 returns the register under the pointer left by earlier transfers.
- R7: On the 9th clock of a read byte the block samples the master. A low (acknowledge) advances the pointer and sends the next register. A high (no acknowledge) releases the line, leaves the pointer unchanged, and waits for a start or stop.
- R8: The data line is only ever pulled low, never driven high. The pull-down is switched on only while the clock is low.
- R9: When the clock line has been low for TIMEOUT_CYC system clocks, the block releases the data line and returns to idle. A partly received write is discarded. Register contents and the pointer are kept.
- R10: After reset the pull-down is off, every register reads 0 and the pointer is 0.
- R11: regs_o shows register k on bits [8k+7:8k] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| strap_i | input | 4 | Low four bits of the own address |
| regs_o | output | NREG*8 | Contents of the register bank |

## Verification
The bench builds the block with four registers and TIMEOUT_CYC = 300. Each bus bit lasts 40 system clocks, so a normal low phase of 20 clocks never trips the timeout, and a deliberate hold of 320 clocks does. Four registers make pointer wrap-around reachable with short multi-byte writes and sequential reads. The timeout can be applied both in the middle of a data byte and while the acknowledge is being driven. The address check sweeps every low nibble against four strap settings, and also tries addresses with wrong upper bits.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_MACK,
    ST_SKIP
  } slv_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int unsigned NLINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] raw_i,
  output logic [NLINE-1:0] lvl_o,
  output logic [NLINE-1:0] rise_o,
  output logic [NLINE-1:0] fall_o
);

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        last_q <= 1'b1;
      end else begin
        meta_q <= raw_i[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign lvl_o[g]  = sync_q;
    assign rise_o[g] = sync_q & ~last_q;
    assign fall_o[g] = ~sync_q & last_q;
  end

endmodule

// File: rtl/twr_lowclk_timer.sv
module twr_lowclk_timer #(
  parameter int unsigned LIMIT = 3_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl_i,
  output logic expired_o
);

  localparam int unsigned TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (scl_lvl_i) begin
      cnt_d = '0;
    end else if (cnt_q != TW'(LIMIT)) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == TW'(LIMIT));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(LIMIT));

endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [IW-1:0]      rd_idx_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] flat_o
);

  logic [DW-1:0] mem_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[k] <= '0;
      else if (hit) mem_q[k] <= wr_data_i;
    end

    assign flat_o[k*DW +: DW] = mem_q[k];
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (flat_o[$past(wr_idx_i)*DW +: DW] == $past(wr_data_i)));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int unsigned NREG        = 4,
  parameter int unsigned TIMEOUT_CYC = 3_500_000,
  parameter logic [2:0]  ADDR_HI     = 3'b110
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scl_i,
  input  logic                             sda_i,
  output logic                             sda_oe,
  input  logic [3:0]                       strap_i,
  output logic [NREG*twr_pkg::BYTE_W-1:0]  regs_o
);
  import twr_pkg::*;

  localparam int unsigned DW     = BYTE_W;
  localparam int unsigned ADDR_W = DW - 1;
  localparam int unsigned PTR_W  = $clog2(NREG);
  localparam int unsigned CNT_W  = $clog2(DW + 1);

  // reset: asynchronous assertion, synchronous release
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  // line conditioning: index 1 = clock, index 0 = data
  logic [1:0] lvl, rise, fall;
  twr_line_sync #(.NLINE(2)) u_sync (
    .clk    (clk),
    .rst_n  (rs_q),
    .raw_i  ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  assign scl_lvl   = lvl[1];
  assign sda_lvl   = lvl[0];
  assign scl_rise  = rise[1];
  assign scl_fall  = fall[1];
  assign start_det = scl_lvl & fall[0];
  assign stop_det  = scl_lvl & rise[0];

  logic expired;
  twr_lowclk_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rs_q),
    .scl_lvl_i (scl_lvl),
    .expired_o (expired)
  );

  slv_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;
  logic              wr_en;
  logic [PTR_W-1:0]  rd_idx;
  logic [DW-1:0]     rd_data;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {ADDR_HI, strap_i};
  assign rd_idx   = (state_q == ST_RD_MACK) ? ptr_q + PTR_W'(1) : ptr_q;

  twr_regbank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rs_q),
    .wr_en_i   (wr_en),
    .wr_idx_i  (ptr_q),
    .wr_data_i (sh_q),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .flat_o    (regs_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rd_d    = rd_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (expired) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && cnt_q != CNT_W'(DW)) begin
            sh_d  = {sh_q[DW-2:0], sda_lvl};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(DW)) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[DW-1:1] == own_addr) begin
                oe_d    = 1'b1;
                rd_d    = sh_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (state_q == ST_CMD) begin
              ptr_d   = sh_q[PTR_W-1:0];
              oe_d    = 1'b1;
              state_d = ST_CMD_ACK;
            end else begin
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WR;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            wr_en   = 1'b1;
            ptr_d   = ptr_q + PTR_W'(1);
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise && cnt_q != CNT_W'(DW)) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(DW)) begin
              oe_d    = 1'b0;
              state_d = ST_RD_MACK;
            end else if (cnt_q != '0) begin
              sh_d = {sh_q[DW-2:0], 1'b0};
              oe_d = ~sh_q[DW-2];
            end
          end
        end
        ST_RD_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              ptr_d   = ptr_q + PTR_W'(1);
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
              state_d = ST_RD;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  // R8
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rs_q)
    $rose(oe_q) |-> !scl_lvl);

  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rs_q)
    expired |=> (!oe_q && state_q == ST_IDLE));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (stop_det && !expired) |=> (state_q == ST_IDLE));

  // R2
  ack_match_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (oe_q && state_q == ST_ADDR_ACK) |-> (sh_q[DW-1:1] == own_addr));

endmodule

// File: tb/tw_reg_slave_bench.sv
`timescale 1ns/1ps
module tw_reg_slave_bench;

  localparam int NREG = 4;
  localparam int TO   = 300;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [3:0] strap = 4'h0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  tw_reg_slave #(.NREG(NREG), .TIMEOUT_CYC(TO)) u_tw_reg_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .strap_i (strap),
    .regs_o  (regs_o)
  );

  int checks = 0;
  int errors = 0;
  int r8_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [NREG];
  logic oe_prev = 1'b0;

  // R8: pull-down may only switch on while the clock line is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && m_scl) r8_viol++;
    oe_prev <= sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic bit_out(input logic b);
    wait_clk(Q); m_sda = b; wait_clk(Q);
    m_scl = 1'b1; wait_clk(2*Q);
    m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wait_clk(Q); m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    b = sda_bus; wait_clk(Q);
    m_scl = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    check({31'd0, ~a}, {31'd0, exp_ack}, tag);
  endtask

  task automatic recv(input logic give_ack, input logic [7:0] expv, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
    check({24'd0, v}, {24'd0, expv}, tag);
  endtask

  task automatic cmp_regs(input string tag);
    for (int k = 0; k < NREG; k++)
      check({24'd0, regs_o[k*8 +: 8]}, {24'd0, exp_r[k]}, tag);
  endtask

  localparam logic [7:0] AW = 8'hD2;  // address 0x69 + write
  localparam logic [7:0] AR = 8'hD3;  // address 0x69 + read

  initial begin
    for (int k = 0; k < NREG; k++) exp_r[k] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R10 reset state
    check({31'd0, sda_oe}, 32'd0, "R10 oe after reset");
    cmp_regs("R10 regs after reset");

    // R2 address sweep against several strap settings
    for (int s = 0; s < 16; s += 5) begin
      strap = 4'(s);
      for (int a = 0; a < 16; a++) begin
        bus_start();
        send({3'b110, 4'(a), 1'b0}, (a == s), "R2 sweep");
        bus_stop();
      end
      bus_start();
      send({3'b010, 4'(s), 1'b0}, 1'b0, "R2 upper bits");
      bus_stop();
      bus_start();
      send({3'b111, 4'(s), 1'b0}, 1'b0, "R2 upper bits");
      bus_stop();
    end
    strap = 4'h9;

    // R3 single write
    bus_start();
    send(AW, 1'b1, "R2 own addr");
    send(8'h01, 1'b1, "R3 cmd ack");
    send(8'hA5, 1'b1, "R3 data ack");
    bus_stop();
    exp_r[1] = 8'hA5;
    cmp_regs("R3 R11 write");

    // R4 multi-byte write with wrap (cmd 6 -> pointer 2)
    bus_start();
    send(AW, 1'b1, "R4 addr");
    send(8'h06, 1'b1, "R4 cmd");
    send(8'h3C, 1'b1, "R4 d0");
    send(8'hC3, 1'b1, "R4 d1");
    send(8'h81, 1'b1, "R4 d2");
    bus_stop();
    exp_r[2] = 8'h3C; exp_r[3] = 8'hC3; exp_r[0] = 8'h81;
    cmp_regs("R4 wrap write");

    // R5 read via repeated start
    bus_start();
    send(AW, 1'b1, "R5 addr");
    send(8'h01, 1'b1, "R5 cmd");
    bus_start();
    send(AR, 1'b1, "R5 addr rd");
    recv(1'b0, exp_r[1], "R5 data");
    bus_stop();

    // R6 direct read, pointer kept through NACK
    bus_start();
    send(AR, 1'b1, "R6 addr rd");
    recv(1'b0, exp_r[1], "R6 data");
    bus_stop();
    check({31'd0, sda_oe}, 32'd0, "R7 released after nack");

    // R7 sequential read with wrap
    bus_start();
    send(AW, 1'b1, "R7 addr");
    send(8'h03, 1'b1, "R7 cmd");
    bus_start();
    send(AR, 1'b1, "R7 addr rd");
    recv(1'b1, exp_r[3], "R7 byte0");
    recv(1'b1, exp_r[0], "R7 byte1 wrap");
    recv(1'b0, exp_r[1], "R7 byte2");
    bus_stop();
    bus_start();
    send(AR, 1'b1, "R7 addr rd2");
    recv(1'b0, exp_r[1], "R7 pointer held on nack");
    bus_stop();

    // R1 stop in the middle of a data byte
    bus_start();
    send(AW, 1'b1, "R1 addr");
    send(8'h00, 1'b1, "R1 cmd");
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    cmp_regs("R1 stop discards");

    // R1 repeated start in the middle of a data byte
    bus_start();
    send(AW, 1'b1, "R1 addr b");
    send(8'h02, 1'b1, "R1 cmd b");
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bus_start();
    send(AW, 1'b1, "R1 restart addr");
    send(8'h02, 1'b1, "R1 restart cmd");
    send(8'h77, 1'b1, "R1 restart data");
    bus_stop();
    exp_r[2] = 8'h77;
    cmp_regs("R1 restart write");

    // R2 foreign address: everything after it is ignored
    bus_start();
    send(8'hA2, 1'b0, "R2 foreign addr");
    send(8'h00, 1'b0, "R2 foreign cmd");
    send(8'hFF, 1'b0, "R2 foreign data");
    bus_stop();
    cmp_regs("R2 foreign ignored");

    // R9 timeout while the acknowledge is driven
    bus_start();
    for (int i = 7; i >= 0; i--) bit_out(AW[i]);
    wait_clk(Q);
    check({31'd0, sda_oe}, 32'd1, "R2 ack driven");
    wait_clk(TO + 20);
    check({31'd0, sda_oe}, 32'd0, "R9 ack released");
    bus_stop();

    // R9 timeout inside a data byte discards it
    bus_start();
    send(AW, 1'b1, "R9 addr");
    send(8'h00, 1'b1, "R9 cmd");
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    wait_clk(TO + 20);
    begin
      logic b;
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      bit_in(b);
      check({31'd0, b}, 32'd1, "R9 no ack after timeout");
    end
    bus_stop();
    cmp_regs("R9 partial write dropped");
    bus_start();
    send(AR, 1'b1, "R9 recover addr");
    recv(1'b0, exp_r[0], "R9 pointer kept");
    bus_stop();

    check(32'(r8_viol), 32'd0, "R8 pull-down on with clock high");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule